// File: doc/BRIEF.md
# Hypercube Slot-Exchange Fabric

This block holds a small hypercube of `2**DIM` processing nodes. Every node owns two 32-slot word stores: an outgoing store and an incoming store. Each store is reached through its own 5-bit slot pointer. The pointer advances by one on every word moved through it and wraps from 31 back to 0. One shared access port serves all nodes, and a node-select input chooses which node it reaches. Software fills outgoing slots one word at a time, issues an exchange, and then drains incoming slots the same way.

An exchange moves data on every dimension at once. For each link number `i` from 1 to `DIM`, the words in outgoing slots `i` and `i+16` cross to the node whose label differs in bit `i-1`. They land in the same two slot numbers of that neighbour's incoming store. Every node therefore sends and receives `2*DIM` words in one step. Slot 0 is not attached to any link, and neither are slots above `DIM` in either half. Incoming slots that no link feeds keep their contents.

Both pointers of one node are set together from a single packed word. The outgoing pointer sits in bits 4:0 and the incoming pointer in bits 9:5. A third transposer field in bits 14:10 and the bits above it have no effect, because this fabric has only two stores per node. An exchange starts only in a cycle with no load or unload, and a one-cycle completion pulse follows it.

Top module: `cube_swap_fabric`

## Requirements
- R1: After reset every pointer is 0, every incoming slot of every node reads 0, and swapDone is low.
- R2: With ptrWrEn high, the selected node's outgoing pointer takes ptrWord[4:0] and its incoming pointer takes ptrWord[9:5]. Bits 31:10 have no effect.
- R3: With loadEn high, loadData is written into the selected node's outgoing slot at its outgoing pointer, and that pointer then advances by one. The pointer wraps from 31 to 0.
- R4: unloadData always shows the selected node's incoming slot at its incoming pointer. With unloadEn high, that pointer advances by one and wraps from 31 to 0.
- R5: An accepted exchange sets incoming slots i and i+16 of node n, for i in 1..DIM, to the outgoing slots i and i+16 of node n XOR 2**(i-1). All nodes and all links update in the same clock edge.
- R6: An exchange leaves incoming slots 0, DIM+1..16 and DIM+17..31 unchanged.
- R7: swapReq is ignored in any cycle where loadEn or unloadEn is high: no incoming slot changes and no done pulse follows. A load in that cycle still takes place.
- R8: swapDone is high for exactly the one cycle that follows the clock edge that accepted an exchange. The exchanged data is readable from that cycle on.
- R9: An exchange leaves every outgoing slot and every pointer unchanged, so a repeated exchange delivers the same words again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeSel | input | DIM | Node reached by pointer, load and unload access |
| ptrWrEn | input | 1 | Load both pointers of the selected node from ptrWord |
| ptrWord | input | 32 | Packed pointers: outgoing in 4:0, incoming in 9:5, rest ignored |
| loadEn | input | 1 | Write loadData into the selected node's outgoing store |
| loadData | input | WORD | Word to write |
| unloadEn | input | 1 | Advance the selected node's incoming pointer |
| unloadData | output | WORD | Incoming slot at the selected node's incoming pointer |
| swapReq | input | 1 | Request an exchange across all links |
| swapDone | output | 1 | One-cycle pulse after an accepted exchange |

## Verification
The first pattern tags each outgoing word with its node, slot and link number. A single full read-back then shows a swapped link, a swapped bit order or a wrong landing slot, because the source of every word can be read from its value. Random words loaded from random start pointers, some of them wrapping, test the pointer arithmetic together with the exchange. The unlinked slots are filled with the same care as the linked ones, so any leak into slots 0 or 5..16 shows up. A request made together with a load, a run of writes that wraps the pointer onto slot 1, and two exchanges in a row check the blocking rule, the wrap and the fact that an exchange does not consume the outgoing data.

// File: rtl/cube_pkg.sv
package cube_pkg;
  localparam int PTR_W = 5;
  localparam int SLOT_CNT = 1 << PTR_W;
  localparam int HALF = SLOT_CNT / 2;

  typedef struct packed {
    logic ptrWr;
    logic load;
    logic unload;
    logic swap;
  } strobe_t;
endpackage

// File: rtl/cube_ctrl.sv
module cube_ctrl
  import cube_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ptrWrEn,
  input  logic [9:0]       ptrFields,
  input  logic             loadEn,
  input  logic             unloadEn,
  input  logic             swapReq,
  output strobe_t          strobes,
  output logic [PTR_W-1:0] sendPtrVal,
  output logic [PTR_W-1:0] recvPtrVal,
  output logic             swapDone
);
  logic swapGo;

  // an exchange waits for a cycle with no slot traffic
  assign swapGo = swapReq && !loadEn && !unloadEn;

  always_comb begin
    strobes.ptrWr  = ptrWrEn;
    strobes.load   = loadEn;
    strobes.unload = unloadEn;
    strobes.swap   = swapGo;
  end

  assign sendPtrVal = ptrFields[PTR_W-1:0];
  assign recvPtrVal = ptrFields[2*PTR_W-1:PTR_W];

  always_ff @(posedge clk) begin
    if (!rstN) swapDone <= 1'b0;
    else       swapDone <= swapGo;
  end

  assert_done_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    swapDone |-> $past(swapReq && !loadEn && !unloadEn));

  assert_blocked_no_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (swapReq && (loadEn || unloadEn)) |=> !swapDone);
endmodule

// File: rtl/cube_node.sv
module cube_node
  import cube_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int WORD = 32,
  localparam int LINKS = 2 * DIM
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sel,
  input  strobe_t               strobes,
  input  logic [PTR_W-1:0]      sendPtrIn,
  input  logic [PTR_W-1:0]      recvPtrIn,
  input  logic [WORD-1:0]       loadData,
  input  logic [LINKS*WORD-1:0] importBus,
  output logic [LINKS*WORD-1:0] exportBus,
  output logic [PTR_W-1:0]      sendPtr,
  output logic [PTR_W-1:0]      recvPtr,
  output logic [WORD-1:0]       readWord
);
  logic [WORD-1:0] sendMem [SLOT_CNT];
  logic [WORD-1:0] recvMem [SLOT_CNT];

  // link lane e: lanes 0..DIM-1 use low slots 1..DIM, the rest use HALF+1..HALF+DIM
  function automatic int laneSlot(input int e);
    return (e < DIM) ? (e + 1) : (e - DIM + HALF + 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sendPtr <= '0;
      recvPtr <= '0;
    end else if (sel && strobes.ptrWr) begin
      sendPtr <= sendPtrIn;
      recvPtr <= recvPtrIn;
    end else if (sel) begin
      if (strobes.load)   sendPtr <= sendPtr + 1'b1;
      if (strobes.unload) recvPtr <= recvPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOT_CNT; s++) sendMem[s] <= '0;
    end else if (sel && strobes.load) begin
      sendMem[sendPtr] <= loadData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SLOT_CNT; s++) recvMem[s] <= '0;
    end else if (strobes.swap) begin
      for (int e = 0; e < LINKS; e++) recvMem[laneSlot(e)] <= importBus[e*WORD +: WORD];
    end
  end

  always_comb begin
    for (int e = 0; e < LINKS; e++) exportBus[e*WORD +: WORD] = sendMem[laneSlot(e)];
  end

  assign readWord = recvMem[recvPtr];

  assert_wire1_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swap |=> recvMem[1] == $past(importBus[WORD-1:0]));

  assert_slot0_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swap |=> recvMem[0] == $past(recvMem[0]));

  assert_mid_slot_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.swap |=> recvMem[HALF] == $past(recvMem[HALF]));

  assert_load_advances_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sel && strobes.load && !strobes.ptrWr) |=> sendPtr == $past(sendPtr) + 5'd1);

  assert_send_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.swap && !strobes.ptrWr) |=> (sendMem[1] == $past(sendMem[1])) && (sendPtr == $past(sendPtr)));
endmodule

// File: rtl/cube_datapath.sv
module cube_datapath
  import cube_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int WORD = 32,
  localparam int NODES = 1 << DIM,
  localparam int LINKS = 2 * DIM
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIM-1:0]   nodeSel,
  input  strobe_t          strobes,
  input  logic [PTR_W-1:0] sendPtrVal,
  input  logic [PTR_W-1:0] recvPtrVal,
  input  logic [31:0]      ptrWord,
  input  logic [WORD-1:0]  loadData,
  output logic [WORD-1:0]  unloadData
);
  logic [NODES-1:0][LINKS*WORD-1:0] exportAll;
  logic [NODES-1:0][LINKS*WORD-1:0] importAll;
  logic [NODES-1:0][WORD-1:0]       readAll;
  logic [NODES-1:0][PTR_W-1:0]      sendPtrAll;
  logic [NODES-1:0][PTR_W-1:0]      recvPtrAll;
  logic [DIM-1:0]                   lastSel;

  for (genvar n = 0; n < NODES; n++) begin : gNode
    cube_node #(.DIM(DIM), .WORD(WORD)) uNode (
      .clk       (clk),
      .rstN      (rstN),
      .sel       (nodeSel == n[DIM-1:0]),
      .strobes   (strobes),
      .sendPtrIn (sendPtrVal),
      .recvPtrIn (recvPtrVal),
      .loadData  (loadData),
      .importBus (importAll[n]),
      .exportBus (exportAll[n]),
      .sendPtr   (sendPtrAll[n]),
      .recvPtr   (recvPtrAll[n]),
      .readWord  (readAll[n])
    );
  end

  // lane e rides link (e mod DIM)+1, reaching the node across bit (e mod DIM)
  always_comb begin
    for (int n = 0; n < NODES; n++) begin
      for (int e = 0; e < LINKS; e++) begin
        importAll[n][e*WORD +: WORD] = exportAll[n ^ (1 << (e % DIM))][e*WORD +: WORD];
      end
    end
  end

  assign unloadData = readAll[nodeSel];

  always_ff @(posedge clk) begin
    if (!rstN) lastSel <= '0;
    else       lastSel <= nodeSel;
  end

  assert_ptr_fields_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ptrWr |=> (sendPtrAll[lastSel] == $past(ptrWord[4:0])) && (recvPtrAll[lastSel] == $past(ptrWord[9:5])));

  assert_spare_bits_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ptrWr && (ptrWord[31:10] != '0)) |=> sendPtrAll[lastSel] == $past(ptrWord[4:0]));

  assert_unload_advances_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.unload && !strobes.ptrWr) |=> recvPtrAll[lastSel] == $past(recvPtrAll[nodeSel]) + 5'd1);
endmodule

// File: rtl/cube_swap_fabric.sv
module cube_swap_fabric
  import cube_pkg::*;
#(
  parameter int DIM  = 4,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DIM-1:0]  nodeSel,
  input  logic            ptrWrEn,
  input  logic [31:0]     ptrWord,
  input  logic            loadEn,
  input  logic [WORD-1:0] loadData,
  input  logic            unloadEn,
  output logic [WORD-1:0] unloadData,
  input  logic            swapReq,
  output logic            swapDone
);
  strobe_t          strobes;
  logic [PTR_W-1:0] sendPtrVal;
  logic [PTR_W-1:0] recvPtrVal;

  cube_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ptrWrEn    (ptrWrEn),
    .ptrFields  (ptrWord[9:0]),
    .loadEn     (loadEn),
    .unloadEn   (unloadEn),
    .swapReq    (swapReq),
    .strobes    (strobes),
    .sendPtrVal (sendPtrVal),
    .recvPtrVal (recvPtrVal),
    .swapDone   (swapDone)
  );

  cube_datapath #(.DIM(DIM), .WORD(WORD)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .nodeSel    (nodeSel),
    .strobes    (strobes),
    .sendPtrVal (sendPtrVal),
    .recvPtrVal (recvPtrVal),
    .ptrWord    (ptrWord),
    .loadData   (loadData),
    .unloadData (unloadData)
  );
endmodule

// File: tb/cube_swap_fabric_bench.sv
module cube_swap_fabric_bench;
  localparam int DIM = 4;
  localparam int NODES = 1 << DIM;
  localparam int SLOTS = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DIM-1:0] nodeSel = '0;
  logic ptrWrEn = 1'b0;
  logic [31:0] ptrWord = '0;
  logic loadEn = 1'b0;
  logic [31:0] loadData = '0;
  logic unloadEn = 1'b0;
  logic [31:0] unloadData;
  logic swapReq = 1'b0;
  logic swapDone;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] mSend [NODES][SLOTS];
  logic [31:0] mRecv [NODES][SLOTS];
  logic [4:0]  mSPtr [NODES];
  logic [4:0]  mRPtr [NODES];

  always #2 clk = ~clk;

  cube_swap_fabric #(.DIM(DIM), .WORD(32)) u_cube_swap_fabric (
    .clk(clk), .rstN(rstN), .nodeSel(nodeSel), .ptrWrEn(ptrWrEn), .ptrWord(ptrWord),
    .loadEn(loadEn), .loadData(loadData), .unloadEn(unloadEn), .unloadData(unloadData),
    .swapReq(swapReq), .swapDone(swapDone)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isLinked(input int s);
    return (s >= 1 && s <= DIM) || (s >= 17 && s <= 16 + DIM);
  endfunction

  // reference exchange computed from R5/R6
  task automatic modelSwap();
    logic [31:0] nxt [NODES][SLOTS];
    for (int n = 0; n < NODES; n++)
      for (int s = 0; s < SLOTS; s++) nxt[n][s] = mRecv[n][s];
    for (int n = 0; n < NODES; n++)
      for (int i = 1; i <= DIM; i++) begin
        nxt[n][i]      = mSend[n ^ (1 << (i - 1))][i];
        nxt[n][i + 16] = mSend[n ^ (1 << (i - 1))][i + 16];
      end
    for (int n = 0; n < NODES; n++)
      for (int s = 0; s < SLOTS; s++) mRecv[n][s] = nxt[n][s];
  endtask

  task automatic setPtr(input int n, input logic [4:0] sp, input logic [4:0] rp);
    logic [21:0] junk = 22'($urandom);
    nodeSel = n[DIM-1:0];
    ptrWord = {junk, rp, sp};
    ptrWrEn = 1'b1;
    @(negedge clk);
    ptrWrEn = 1'b0;
    mSPtr[n] = sp;
    mRPtr[n] = rp;
  endtask

  task automatic loadWord(input int n, input logic [31:0] d);
    nodeSel = n[DIM-1:0];
    loadData = d;
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    mSend[n][mSPtr[n]] = d;
    mSPtr[n] = mSPtr[n] + 5'd1;
  endtask

  task automatic doSwap();
    swapReq = 1'b1;
    @(posedge clk);
    #1;
    swapReq = 1'b0;
    check("R8 done pulse high", {31'd0, swapDone}, 32'd1);
    modelSwap();
    @(posedge clk);
    #1;
    check("R8 done pulse single", {31'd0, swapDone}, 32'd0);
    @(negedge clk);
  endtask

  // drain every incoming slot of every node starting at slot 0
  task automatic readAll(input string phase);
    for (int n = 0; n < NODES; n++) begin
      setPtr(n, mSPtr[n], 5'd0);
      for (int s = 0; s < SLOTS; s++) begin
        nodeSel = n[DIM-1:0];
        unloadEn = 1'b1;
        #1;
        if (phase == "R1")      check("R1 reset incoming slot", unloadData, mRecv[n][s]);
        else if (isLinked(s))   check("R5 linked slot", unloadData, mRecv[n][s]);
        else                    check("R6 unlinked slot kept", unloadData, mRecv[n][s]);
        @(negedge clk);
        unloadEn = 1'b0;
        mRPtr[n] = mRPtr[n] + 5'd1;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int n = 0; n < NODES; n++) begin
      mSPtr[n] = '0;
      mRPtr[n] = '0;
      for (int s = 0; s < SLOTS; s++) begin
        mSend[n][s] = '0;
        mRecv[n][s] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 swapDone low", {31'd0, swapDone}, 32'd0);
    check("R1 reset unload word", unloadData, 32'd0);
    @(negedge clk);
    readAll("R1");

    // R4: after 32 unloads node 0 pointer wrapped back to slot 0
    nodeSel = '0;
    unloadEn = 1'b1;
    #1;
    check("R4 pointer wrap reads slot 0", unloadData, mRecv[0][0]);
    @(negedge clk);
    unloadEn = 1'b0;
    mRPtr[0] = mRPtr[0] + 5'd1;

    // directed: tagged words {node, slot, link, marker}
    for (int n = 0; n < NODES; n++) begin
      setPtr(n, 5'd0, 5'd0);
      for (int s = 0; s < SLOTS; s++)
        loadWord(n, {8'(n), 8'(s), 8'(s % 16), 8'hA5});
    end
    doSwap();
    readAll("X");

    // random words from random start pointers, some wrapping
    for (int round = 0; round < 3; round++) begin
      for (int n = 0; n < NODES; n++) begin
        setPtr(n, 5'($urandom), 5'd0);
        for (int k = 0; k < int'($urandom_range(40)); k++) loadWord(n, $urandom);
      end
      doSwap();
      readAll("X");
    end

    // R7: exchange requested together with a load is ignored
    setPtr(3, 5'd2, 5'd0);
    nodeSel = 4'd3;
    loadData = 32'hDEAD_0003;
    loadEn = 1'b1;
    swapReq = 1'b1;
    @(posedge clk);
    #1;
    loadEn = 1'b0;
    swapReq = 1'b0;
    mSend[3][2] = 32'hDEAD_0003;
    mSPtr[3] = 5'd3;
    check("R7 no done when blocked", {31'd0, swapDone}, 32'd0);
    @(negedge clk);
    setPtr(1, mSPtr[1], 5'd2);
    nodeSel = 4'd1;
    #1;
    check("R7 incoming unchanged", unloadData, mRecv[1][2]);
    @(negedge clk);
    doSwap();
    setPtr(1, mSPtr[1], 5'd2);
    #1;
    check("R7 load during blocked cycle kept", unloadData, 32'hDEAD_0003);
    @(negedge clk);

    // R3: outgoing pointer wraps 31 -> 0 -> 1
    setPtr(0, 5'd31, 5'd0);
    loadWord(0, 32'h1111_0031);
    loadWord(0, 32'h1111_0000);
    loadWord(0, 32'h1111_0001);
    doSwap();
    setPtr(1, mSPtr[1], 5'd1);
    #1;
    check("R3 wrapped load reaches slot 1", unloadData, 32'h1111_0001);
    @(negedge clk);

    // R2: pointer word with random spare bits selects incoming slot 17
    setPtr(7, mSPtr[7], 5'd17);
    #1;
    check("R2 packed pointer field", unloadData, mRecv[7][17]);
    @(negedge clk);

    // R9: a repeated exchange with no loads delivers identical words
    doSwap();
    readAll("X");
    setPtr(1, mSPtr[1], 5'd1);
    #1;
    check("R9 repeated exchange same word", unloadData, 32'h1111_0001);
    @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule